// File: doc/BRIEF.md
# Transmit Completion Ring Writer

This block posts transmit-result records into a circular ring of sixteen entries that a host drains. Each completion event carries a packet id, a status code, a retry (acknowledgement failure) count, the rate at which the acknowledgement arrived, a low sequence byte and three timing values. For each event that asks for a report, the writer claims the next ring entry, fills it and hands it to the host. Events that do not ask for a report are taken and dropped.

Ownership of an entry lives in two flag bytes, one at each end of the record. The writer raises the leading flag first, then writes the payload, then raises the trailing flag. A reader that finds both flags set therefore holds a whole record. The host gives an entry back by clearing both flags through its release port. If the entry under the write pointer is still held by the host, the writer refuses new events until that entry is released.

A completion interrupt is raised at once for records that ask for it. Otherwise it is raised when the number of records posted since the last acknowledge reaches a 5-bit programmable threshold. The ring is held in registers. A read port presents any entry as a 160-bit record.

Top module: `trc_ring_writer`

## Requirements
- R1: After reset every entry reads as all zeros, with both flags clear. The event input is ready, the interrupt is low and the write pointer is at entry 0.
- R2: A record read from `host_rec` is little-endian by byte offset, with bit = offset × 8:
  - byte 0: leading flag
  - byte 1: id
  - bytes 2–3: air time
  - bytes 4–7: queue delay
  - bytes 8–11: firmware time
  - byte 12: sequence low byte
  - byte 13: acknowledgement failures
  - bytes 14–15: rate
  - bytes 16–17: reserved, read as zero
  - byte 18: status
  - byte 19: trailing flag

  A set flag reads 0x01 and a clear flag reads 0x00. The id equals the event's id.
- R3: For an event accepted at clock edge k, the leading flag reads set after edge k+1. The payload appears after edge k+2. The trailing flag is set after edge k+3 and never earlier than the payload.
- R4: Reported records fill entries 0,1,…,15 in order and then wrap to entry 0.
- R5: `evt_ready` is high only when the writer is idle and the entry at the write pointer has both flags clear. While it is low, a presented event is held off and nothing is written.
- R6: An accepted event with `evt_report` low writes no entry, leaves the write pointer unchanged and does not touch the pending count or the interrupt.
- R7: A record whose event had `evt_irq_each` set raises `irq` at the same edge that sets its trailing flag.
- R8: Each posted record adds one to a pending count, which saturates at 31. When the new count is at least `agg_thresh`, and `agg_thresh` is non-zero, `irq` is raised. A threshold of 0 turns aggregation off.
- R9: `irq_ack` clears `irq` and the pending count at the next edge. If a record completes at that same edge, the clear is applied first and the record is then counted from zero, with its interrupt condition judged on that new count.
- R10: `host_release` clears both flags of entry `host_idx` at the next edge. If the writer sets a flag of the same entry at that edge, the writer's set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event present |
| evt_ready | output | 1 | Event taken at this edge when high with evt_valid |
| evt_report | input | 1 | Event asks for a ring record |
| evt_irq_each | input | 1 | Raise the interrupt for this record alone |
| evt_id | input | 8 | Packet id |
| evt_status | input | 8 | Completion status code |
| evt_ack_fail | input | 8 | Acknowledgement failure count |
| evt_seq_lo | input | 8 | Low byte of the sequence number |
| evt_rate | input | 16 | Rate of the acknowledgement |
| evt_air_time | input | 16 | Air time used by the packet |
| evt_queue_delay | input | 32 | Medium access delay |
| evt_fw_time | input | 32 | Handling time inside the device |
| agg_thresh | input | 5 | Aggregation threshold, 0 = off |
| irq | output | 1 | Completion interrupt, level |
| irq_ack | input | 1 | Acknowledge: clear interrupt and pending count |
| host_idx | input | 4 | Entry selected for read and release |
| host_rec | output | 160 | Record at host_idx |
| host_release | input | 1 | Clear both flags of entry host_idx |

## Verification
Two pairs of functions can fall in the same cycle, and the bench targets both. The first pair is an interrupt acknowledge and the completion of a record. The bench raises the acknowledge exactly on the trailing-flag edge while the interrupt is already high from the threshold. It expects the interrupt to drop because the count restarts at one; the next record must then raise it again. The second pair is a host release and a writer flag set on the same entry. The bench releases the entry under the write pointer during the leading-flag edge and expects the flag to read set. Randomised traffic with random releases and acknowledges then runs against a behavioural model compared on every clock.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int unsigned REC_W = 160;

    typedef struct packed {
        logic [7:0]  id;
        logic [15:0] air_time;
        logic [31:0] queue_delay;
        logic [31:0] fw_time;
        logic [7:0]  seq_lo;
        logic [7:0]  ack_fail;
        logic [15:0] rate;
        logic [7:0]  status;
    } trc_body_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_BODY = 2'd2,
        PH_TAIL = 2'd3
    } trc_phase_e;

endpackage

// File: rtl/trc_ring_store.sv
module trc_ring_store
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_head,
    input  logic             wr_body,
    input  logic             set_tail,
    input  logic [PTR_W-1:0] wr_idx,
    input  trc_body_t        body_in,
    input  logic             clr_en,
    input  logic [PTR_W-1:0] clr_idx,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [REC_W-1:0] rd_rec,
    output logic             slot_free
);

    typedef struct packed {
        logic [DEPTH-1:0]            lead;
        logic [DEPTH-1:0]            trail;
        trc_body_t [DEPTH-1:0]       body;
    } store_t;

    store_t st_d, st_q;
    trc_body_t rd_body;

    // R10: host clear first, writer sets applied after so they win
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (clr_en && (clr_idx == PTR_W'(i))) begin
                st_d.lead[i]  = 1'b0;
                st_d.trail[i] = 1'b0;
            end
            if (wr_idx == PTR_W'(i)) begin
                if (set_head) st_d.lead[i]  = 1'b1;
                if (wr_body)  st_d.body[i]  = body_in;
                if (set_tail) st_d.trail[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: byte layout of the host-visible record
    always_comb begin
        rd_body = st_q.body[rd_idx];
        rd_rec  = {7'b0, st_q.trail[rd_idx],
                   rd_body.status,
                   16'h0000,
                   rd_body.rate,
                   rd_body.ack_fail,
                   rd_body.seq_lo,
                   rd_body.fw_time,
                   rd_body.queue_delay,
                   rd_body.air_time,
                   rd_body.id,
                   7'b0, st_q.lead[rd_idx]};
        slot_free = !st_q.lead[wr_idx] && !st_q.trail[wr_idx];
    end

endmodule

// File: rtl/trc_write_fsm.sv
module trc_write_fsm
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_report,
    input  logic             evt_each,
    input  trc_body_t        evt_body,
    input  logic             slot_free,
    output logic             evt_ready,
    output logic             set_head,
    output logic             wr_body,
    output logic             set_tail,
    output logic             rec_each,
    output logic [PTR_W-1:0] wr_idx,
    output trc_body_t        hold_body
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        trc_phase_e       ph;
        logic [PTR_W-1:0] ptr;
        trc_body_t        hold;
        logic             each;
    } fsm_t;

    fsm_t fs_d, fs_q;

    always_comb begin
        fs_d      = fs_q;
        evt_ready = (fs_q.ph == PH_IDLE) && slot_free;
        unique case (fs_q.ph)
            PH_IDLE: begin
                // R6: unreported events are taken and dropped
                if (evt_valid && evt_ready && evt_report) begin
                    fs_d.ph   = PH_HEAD;
                    fs_d.hold = evt_body;
                    fs_d.each = evt_each;
                end
            end
            PH_HEAD: fs_d.ph = PH_BODY;
            PH_BODY: fs_d.ph = PH_TAIL;
            PH_TAIL: begin
                fs_d.ph  = PH_IDLE;
                fs_d.ptr = (fs_q.ptr == LAST) ? '0 : fs_q.ptr + 1'b1;
            end
            default: fs_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign set_head  = (fs_q.ph == PH_HEAD);
    assign wr_body   = (fs_q.ph == PH_BODY);
    assign set_tail  = (fs_q.ph == PH_TAIL);
    assign rec_each  = fs_q.each;
    assign wr_idx    = fs_q.ptr;
    assign hold_body = fs_q.hold;

endmodule

// File: rtl/trc_irq_agg.sv
module trc_irq_agg #(
    parameter int unsigned THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_done,
    input  logic             rec_each,
    input  logic [THR_W-1:0] thresh,
    input  logic             ack,
    output logic             irq
);

    typedef struct packed {
        logic [THR_W-1:0] pend;
        logic             irq;
    } agg_t;

    agg_t ag_d, ag_q;
    logic [THR_W-1:0] base;
    logic [THR_W-1:0] nxt;

    // R9: acknowledge clears first, a coincident completion counts after
    always_comb begin
        ag_d     = ag_q;
        base     = ack ? '0 : ag_q.pend;
        nxt      = (base == '1) ? base : base + 1'b1;
        ag_d.irq = ag_q.irq && !ack;
        ag_d.pend = base;
        if (rec_done) begin
            ag_d.pend = nxt;
            if (rec_each || ((thresh != '0) && (nxt >= thresh)))
                ag_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign irq = ag_q.irq;

endmodule

// File: rtl/trc_ring_writer.sv
module trc_ring_writer
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned THR_W = 5,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic             evt_report,
    input  logic             evt_irq_each,
    input  logic [7:0]       evt_id,
    input  logic [7:0]       evt_status,
    input  logic [7:0]       evt_ack_fail,
    input  logic [7:0]       evt_seq_lo,
    input  logic [15:0]      evt_rate,
    input  logic [15:0]      evt_air_time,
    input  logic [31:0]      evt_queue_delay,
    input  logic [31:0]      evt_fw_time,
    input  logic [THR_W-1:0] agg_thresh,
    output logic             irq,
    input  logic             irq_ack,
    input  logic [PTR_W-1:0] host_idx,
    output logic [REC_W-1:0] host_rec,
    input  logic             host_release
);

    trc_body_t        evt_body;
    trc_body_t        hold_body;
    logic             slot_free;
    logic             set_head;
    logic             wr_body;
    logic             set_tail;
    logic             rec_each;
    logic [PTR_W-1:0] wr_idx;

    always_comb begin
        evt_body.id          = evt_id;
        evt_body.air_time    = evt_air_time;
        evt_body.queue_delay = evt_queue_delay;
        evt_body.fw_time     = evt_fw_time;
        evt_body.seq_lo      = evt_seq_lo;
        evt_body.ack_fail    = evt_ack_fail;
        evt_body.rate        = evt_rate;
        evt_body.status      = evt_status;
    end

    trc_write_fsm #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_report(evt_report),
        .evt_each  (evt_irq_each),
        .evt_body  (evt_body),
        .slot_free (slot_free),
        .evt_ready (evt_ready),
        .set_head  (set_head),
        .wr_body   (wr_body),
        .set_tail  (set_tail),
        .rec_each  (rec_each),
        .wr_idx    (wr_idx),
        .hold_body (hold_body)
    );

    trc_ring_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_head (set_head),
        .wr_body  (wr_body),
        .set_tail (set_tail),
        .wr_idx   (wr_idx),
        .body_in  (hold_body),
        .clr_en   (host_release),
        .clr_idx  (host_idx),
        .rd_idx   (host_idx),
        .rd_rec   (host_rec),
        .slot_free(slot_free)
    );

    trc_irq_agg #(.THR_W(THR_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rec_done(set_tail),
        .rec_each(rec_each),
        .thresh  (agg_thresh),
        .ack     (irq_ack),
        .irq     (irq)
    );

endmodule

// File: rtl/trc_ring_writer_chk.sv
module trc_ring_writer_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic             evt_report,
    input logic             irq,
    input logic             irq_ack,
    input logic             set_head,
    input logic             wr_body,
    input logic             set_tail,
    input logic             rec_each,
    input logic [PTR_W-1:0] wr_idx
);

    p_tail_after_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_tail |-> $past(wr_body));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_tail |=> (wr_idx == (($past(wr_idx) == PTR_W'(DEPTH - 1)) ? '0 : $past(wr_idx) + 1'b1)));

    p_busy_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && evt_report) |=> !evt_ready);

    p_drop_unreported_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && !evt_report) |=> (!set_head && $stable(wr_idx)));

    p_each_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_tail && rec_each) |=> irq);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !set_tail) |=> !irq);

endmodule

bind trc_ring_writer trc_ring_writer_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_report(evt_report),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .set_head  (set_head),
    .wr_body   (wr_body),
    .set_tail  (set_tail),
    .rec_each  (rec_each),
    .wr_idx    (wr_idx)
);

// File: tb/test_trc_ring_writer.sv
`timescale 1ns/1ps
module test_trc_ring_writer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_valid = 1'b0;
    logic         evt_ready;
    logic         evt_report = 1'b0;
    logic         evt_irq_each = 1'b0;
    logic [7:0]   evt_id = '0;
    logic [7:0]   evt_status = '0;
    logic [7:0]   evt_ack_fail = '0;
    logic [7:0]   evt_seq_lo = '0;
    logic [15:0]  evt_rate = '0;
    logic [15:0]  evt_air_time = '0;
    logic [31:0]  evt_queue_delay = '0;
    logic [31:0]  evt_fw_time = '0;
    logic [4:0]   agg_thresh = '0;
    logic         irq;
    logic         irq_ack = 1'b0;
    logic [3:0]   host_idx = '0;
    logic [159:0] host_rec;
    logic         host_release = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit live = 0;

    always #2 clk = ~clk;

    trc_ring_writer i_trc_ring_writer (.*);

    // behavioural reference
    bit           m_f1 [16];
    bit           m_f2 [16];
    logic [143:0] m_mid [16];
    logic [143:0] m_hold;
    bit           m_each;
    int           m_ph, m_wp, m_pend;
    bit           m_irq;

    function automatic logic [143:0] mid_of();
        return {evt_status, 16'h0000, evt_rate, evt_ack_fail, evt_seq_lo,
                evt_fw_time, evt_queue_delay, evt_air_time, evt_id};
    endfunction

    function automatic logic [159:0] exp_rec(int i);
        return {7'b0, m_f2[i], m_mid[i], 7'b0, m_f1[i]};
    endfunction

    function automatic bit m_ready();
        return (m_ph == 0) && !m_f1[m_wp] && !m_f2[m_wp];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_f1[i]) begin m_f1[i] = 0; m_f2[i] = 0; m_mid[i] = '0; end
            m_ph = 0; m_wp = 0; m_pend = 0; m_irq = 0; m_each = 0; m_hold = '0;
        end else begin
            bit rdy, done, irqn;
            int base;
            rdy = m_ready();
            done = 0;
            if (host_release) begin m_f1[host_idx] = 0; m_f2[host_idx] = 0; end
            case (m_ph)
                0: if (evt_valid && rdy && evt_report) begin
                       m_hold = mid_of(); m_each = evt_irq_each; m_ph = 1;
                   end
                1: begin m_f1[m_wp] = 1; m_ph = 2; end
                2: begin m_mid[m_wp] = m_hold; m_ph = 3; end
                default: begin m_f2[m_wp] = 1; m_wp = (m_wp + 1) % 16; m_ph = 0; done = 1; end
            endcase
            base = irq_ack ? 0 : m_pend;
            irqn = m_irq && !irq_ack;
            if (done) begin
                base = (base == 31) ? 31 : base + 1;
                if (m_each || (agg_thresh != 0 && base >= int'(agg_thresh))) irqn = 1;
            end
            m_pend = base;
            m_irq = irqn;
        end
    end

    task automatic chk(string tag, logic [159:0] act, logic [159:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && live) begin
            chk("R5 ready", 160'(evt_ready), 160'(m_ready()));
            chk("R8 irq", 160'(irq), 160'(m_irq));
            chk("R2 record", host_rec, exp_rec(int'(host_idx)));
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(logic [7:0] id, bit each, bit rep);
        evt_id = id; evt_irq_each = each; evt_report = rep;
        evt_status = id ^ 8'h5A; evt_ack_fail = id >> 2; evt_seq_lo = ~id;
        evt_rate = {id, 8'h0B}; evt_air_time = {8'h01, id};
        evt_queue_delay = {4{id}} ^ 32'h1234_0000; evt_fw_time = {id, 24'hABCDEF};
    endtask

    // returns one time unit after the accepting edge
    task automatic send(logic [7:0] id, bit each, bit rep);
        bit hit;
        load(id, each, rep);
        evt_valid = 1'b1;
        do begin
            hit = evt_ready;
            tick();
        end while (!hit);
        evt_valid = 1'b0;
    endtask

    task automatic post(logic [7:0] id, bit each);
        send(id, each, 1'b1);
        repeat (3) tick();
    endtask

    task automatic release_idx(int i);
        host_idx = 4'(i); host_release = 1'b1;
        tick();
        host_release = 1'b0;
    endtask

    initial begin
        logic [159:0] want;
        int hp;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        live = 1;

        // R1 reset state
        chk("R1 ready", 160'(evt_ready), 160'd1);
        chk("R1 irq", 160'(irq), 160'd0);
        for (int i = 0; i < 16; i++) begin
            host_idx = 4'(i); #0.1;
            chk("R1 entry", host_rec, '0);
        end
        host_idx = 0;

        // R3 ordering, R2 layout, R7 per-packet interrupt
        agg_thresh = 0;
        send(8'h11, 1'b1, 1'b1);
        chk("R3 lead not yet", 160'(host_rec[7:0]), 160'd0);
        tick();
        chk("R3 lead set", 160'(host_rec[7:0]), 160'd1);
        chk("R3 body not yet", 160'(host_rec[15:8]), 160'd0);
        tick();
        chk("R3 tail not yet", 160'(host_rec[159:152]), 160'd0);
        tick();
        want = {8'h01, 8'h4B, 16'h0, 16'h110B, 8'h04, 8'hEE, 32'h11AB_CDEF,
                32'h0325_1111, 16'h0111, 8'h11, 8'h01};
        chk("R2 full record", host_rec, want);
        chk("R7 irq each", 160'(irq), 160'd1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R9 ack clears", 160'(irq), 160'd0);

        // R6 unreported event
        send(8'h22, 1'b0, 1'b0);
        repeat (3) tick();
        host_idx = 1; #0.1;
        chk("R6 no entry", host_rec, '0);
        chk("R6 no irq", 160'(irq), 160'd0);

        // R8 aggregation threshold 3
        agg_thresh = 3;
        post(8'h31, 0); post(8'h32, 0);
        chk("R8 below thr", 160'(irq), 160'd0);
        chk("R4 second slot", 160'(host_rec[15:8]), 160'h31);
        post(8'h33, 0);
        chk("R8 at thr", 160'(irq), 160'd1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;

        // R9 acknowledge coinciding with a completion
        agg_thresh = 2;
        post(8'h41, 0); post(8'h42, 0);
        chk("R9 pre irq", 160'(irq), 160'd1);
        send(8'h43, 0, 1);
        tick(); tick();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R9 recount", 160'(irq), 160'd0);
        post(8'h44, 0);
        chk("R9 count was one", 160'(irq), 160'd1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;

        // R5 stall on a full ring, R4 wrap
        agg_thresh = 0;
        for (int i = 0; i < 8; i++) release_idx(i);
        for (int i = 0; i < 16; i++) post(8'(8'h50 + i), 0);
        load(8'h77, 0, 1);
        evt_valid = 1'b1;
        repeat (5) tick();
        chk("R5 stalled", 160'(evt_ready), 160'd0);
        host_idx = 8; #0.1;
        chk("R5 not overwritten", 160'(host_rec[15:8]), 160'h50);
        evt_valid = 1'b0;
        release_idx(8);
        post(8'h77, 0);
        host_idx = 8; #0.1;
        chk("R4 wrap to released", 160'(host_rec[15:8]), 160'h77);

        // R10 writer wins over a same-entry release
        for (int i = 0; i < 16; i++) release_idx(i);
        send(8'h88, 0, 1);
        host_idx = 4'(m_wp); host_release = 1'b1;
        tick();
        host_release = 1'b0;
        chk("R10 writer wins", 160'(host_rec[7:0]), 160'd1);
        tick(); tick();
        release_idx(int'(host_idx));
        chk("R10 released", 160'(host_rec[159:152]), 160'd0);

        // randomised traffic
        hp = m_wp;
        for (int n = 0; n < 3000; n++) begin
            load(8'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 5 != 0));
            evt_valid = 1'($urandom % 2);
            irq_ack = 1'($urandom % 8 == 0);
            if (n % 200 == 0) agg_thresh = 5'($urandom);
            host_release = 1'b0;
            host_idx = 4'($urandom);
            if (($urandom % 3 == 0) && m_f1[hp] && m_f2[hp]) begin
                host_idx = 4'(hp); host_release = 1'b1; hp = (hp + 1) % 16;
            end
            tick();
        end
        evt_valid = 1'b0; irq_ack = 1'b0; host_release = 1'b0;
        repeat (4) tick();
        finish_run();
    end

endmodule